// File: doc/BRIEF.md
# Store Buffer with Fence Gating

This block holds stores that have already committed and writes them, oldest first, into the data cache through a plain ready/valid write port. The drain never waits for anything and never speeds up: the head store goes out in any cycle where the cache accepts a write, whether or not an ordering event is pending. While the head waits, younger entries can send read-for-ownership prefetches for their cache lines, so several store misses can be in progress at once. These prefetches are limited by how many fill buffers the memory side reports as free.

Ordering events reach the block from dispatch as a fence marker with a kind code. A fence does not flush anything. It only chooses which younger instruction classes are held back until every store older than the fence has left the buffer. A store-load fence holds loads. An atomic holds loads and stores, and it stalls allocation once a younger memory operation shows up at dispatch. A full fence holds every younger instruction.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the buffer is empty: `enq_ready`=1, and `wr_valid`, `pf_valid`, `stall_load`, `stall_store`, `stall_all` and `stall_dispatch` are all 0.
- R2: `wr_valid` is high whenever the buffer is not empty. `wr_addr`/`wr_data` show the oldest store, which leaves on a cycle with `wr_valid` and `wr_ready` both high. Stores drain in enqueue order, and pending fences have no effect on the drain.
- R3: `enq_ready` is 0 exactly when DEPTH stores are held. An enqueue and a drain in the same cycle are both performed.
- R4: A fence with `fence_kind`=0 (store-load) raises `stall_load` in the cycle after the marker. It does not raise `stall_store` or `stall_all`.
- R5: A fence with `fence_kind`=1 (atomic) raises both `stall_load` and `stall_store` in the cycle after the marker. It leaves `stall_all` low.
- R6: While an atomic is pending, `stall_dispatch` stays low until `disp_mem` (a younger load or store is at dispatch) is seen high. It goes high in that same cycle and stays high until the atomic's stall drops.
- R7: A fence with `fence_kind`=2 (full) raises `stall_load`, `stall_store`, `stall_all` and `stall_dispatch` in the cycle after the marker.
- R8: A fence's stall ends one cycle after the buffer has written out every store that is older than the fence. An enqueue in the marker's own cycle counts as older. With no older stores the stall lasts exactly one cycle.
- R9: `pf_valid` offers the line address (`addr` with its low LINE_LSB=6 bits cleared) of the oldest entry that is not the head and has not yet been prefetched. It is offered only while `fill_free` >= 2. Each entry is prefetched at most once.
- R10: A marker with `fence_kind`=3 has no effect on any stall output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | A committed store is offered |
| enq_addr | input | 32 | Store address |
| enq_data | input | 32 | Store data |
| enq_ready | output | 1 | Buffer can take a store |
| wr_valid | output | 1 | Cache write request for the head store |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | 32 | Head store address |
| wr_data | output | 32 | Head store data |
| fence_valid | input | 1 | Ordering marker from dispatch |
| fence_kind | input | 2 | 0 store-load, 1 atomic, 2 full, 3 none |
| disp_mem | input | 1 | A younger load or store is at dispatch |
| fill_free | input | FB_W (3) | Number of free fill buffers |
| pf_valid | output | 1 | Ownership prefetch request |
| pf_addr | output | 32 | Line address to prefetch |
| stall_load | output | 1 | Hold load issue |
| stall_store | output | 1 | Hold store issue |
| stall_all | output | 1 | Hold all instruction issue |
| stall_dispatch | output | 1 | Hold allocation at dispatch |

## Verification
The assertions assume that dispatch obeys the stalls. No store is enqueued while `stall_store` is high, and no new fence arrives while another fence is still pending. Without these conditions the end of an atomic's stall would not coincide with an empty buffer. The random stimulus enables enqueues only when the bench model shows no atomic or full fence pending, and it sends a fence only when no fence of any kind is pending. The directed cases follow the same rules.

// File: rtl/sdq_pkg.sv
`timescale 1ns/1ps
package sdq_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int NUM_KINDS = 3;

    typedef enum logic [1:0] {
        FK_STORE_LOAD = 2'd0,
        FK_ATOMIC     = 2'd1,
        FK_FULL       = 2'd2,
        FK_NONE       = 2'd3
    } fence_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } store_t;

    // Clear the byte-offset bits of an address to get its cache line.
    function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a, input int lsb);
        return (a >> lsb) << lsb;
    endfunction

    function automatic int wrap_add(input int p, input int k, input int depth);
        int s;
        s = p + k;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/sdq_ring.sv
`timescale 1ns/1ps
module sdq_ring
    import sdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  store_t            push_st,
    input  logic              pop,
    input  logic              mark,
    input  logic [PTR_W-1:0]  mark_idx,
    input  logic [PTR_W-1:0]  rd_idx,
    output store_t            head_st,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  head_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [DEPTH-1:0]  sent
);

    store_t             slots [DEPTH];
    logic [PTR_W-1:0]   wp_q, rp_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DEPTH-1:0]   sent_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wp_q] <= push_st;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            sent_q <= '0;
        end else begin
            if (mark) sent_q[mark_idx] <= 1'b1;
            if (push) begin
                sent_q[wp_q] <= 1'b0;
                wp_q         <= step(wp_q);
            end
            if (pop) rp_q <= step(rp_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_st  = slots[rp_q];
    assign rd_addr  = slots[rd_idx].addr;
    assign head_ptr = rp_q;
    assign count    = cnt_q;
    assign sent     = sent_q;

endmodule

// File: rtl/sdq_pf_pick.sv
`timescale 1ns/1ps
module sdq_pf_pick
    import sdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic [PTR_W-1:0] head_ptr,
    input  logic [CNT_W-1:0] count,
    input  logic [DEPTH-1:0] sent,
    output logic             hit,
    output logic [PTR_W-1:0] idx
);

    // Oldest non-head occupied slot whose prefetch has not gone out.
    always_comb begin
        int s;
        hit = 1'b0;
        idx = '0;
        s   = 0;
        for (int k = DEPTH - 1; k >= 1; k--) begin
            s = wrap_add(int'(head_ptr), k, DEPTH);
            if ((CNT_W'(k) < count) && !sent[s]) begin
                hit = 1'b1;
                idx = PTR_W'(s);
            end
        end
    end

endmodule

// File: rtl/sdq_fence_track.sv
`timescale 1ns/1ps
module sdq_fence_track #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_cnt,
    input  logic             dec,
    output logic             pend
);

    logic             pend_q;
    logic [CNT_W-1:0] left_q;

    // left_q counts stores older than the fence still in the buffer.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            left_q <= '0;
        end else if (arm) begin
            pend_q <= 1'b1;
            left_q <= arm_cnt;
        end else begin
            if (pend_q && left_q == '0) pend_q <= 1'b0;
            if (dec && left_q != '0)    left_q <= left_q - 1'b1;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/store_drain_queue.sv
`timescale 1ns/1ps
module store_drain_queue
    import sdq_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int LINE_LSB    = 6,
    parameter int FB_W        = 3,
    parameter int PF_MIN_FREE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    output logic              enq_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              fence_valid,
    input  logic [1:0]        fence_kind,
    input  logic              disp_mem,
    input  logic [FB_W-1:0]   fill_free,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              stall_load,
    output logic              stall_store,
    output logic              stall_all,
    output logic              stall_dispatch
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    store_t             head_st;
    logic [ADDR_W-1:0]  pick_addr;
    logic [PTR_W-1:0]   head_ptr, pick_idx;
    logic [CNT_W-1:0]   count, occ_next;
    logic [DEPTH-1:0]   sent;
    logic               pick_hit, enq_fire, drain, pf_fire;
    logic [NUM_KINDS-1:0] pend;
    logic               mem_seen_q;

    assign enq_ready = (count != CNT_W'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;
    assign wr_valid  = (count != '0);
    assign drain     = wr_valid && wr_ready;
    assign wr_addr   = head_st.addr;
    assign wr_data   = head_st.data;

    always_comb begin
        case ({enq_fire, drain})
            2'b10:   occ_next = count + 1'b1;
            2'b01:   occ_next = count - 1'b1;
            default: occ_next = count;
        endcase
    end

    sdq_ring #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (enq_fire),
        .push_st  ('{addr: enq_addr, data: enq_data}),
        .pop      (drain),
        .mark     (pf_fire),
        .mark_idx (pick_idx),
        .rd_idx   (pick_idx),
        .head_st  (head_st),
        .rd_addr  (pick_addr),
        .head_ptr (head_ptr),
        .count    (count),
        .sent     (sent)
    );

    sdq_pf_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_pick (
        .head_ptr (head_ptr),
        .count    (count),
        .sent     (sent),
        .hit      (pick_hit),
        .idx      (pick_idx)
    );

    // Throttle: prefetch only with enough fill-buffer headroom.
    assign pf_fire  = pick_hit && (fill_free >= FB_W'(PF_MIN_FREE));
    assign pf_valid = pf_fire;
    assign pf_addr  = line_of(pick_addr, LINE_LSB);

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_fence
        sdq_fence_track #(.CNT_W(CNT_W)) u_trk (
            .clk     (clk),
            .rst     (rst),
            .arm     (fence_valid && (fence_kind == 2'(g))),
            .arm_cnt (occ_next),
            .dec     (drain),
            .pend    (pend[g])
        );
    end

    // Sticky: a younger memory op reached dispatch under an atomic.
    always_ff @(posedge clk) begin
        if (rst)                     mem_seen_q <= 1'b0;
        else if (!pend[FK_ATOMIC])   mem_seen_q <= 1'b0;
        else if (disp_mem)           mem_seen_q <= 1'b1;
    end

    assign stall_load     = pend[FK_STORE_LOAD] | pend[FK_ATOMIC] | pend[FK_FULL];
    assign stall_store    = pend[FK_ATOMIC] | pend[FK_FULL];
    assign stall_all      = pend[FK_FULL];
    assign stall_dispatch = pend[FK_FULL] | (pend[FK_ATOMIC] & (mem_seen_q | disp_mem));

endmodule

// File: rtl/sdq_checker.sv
`timescale 1ns/1ps
module sdq_checker #(
    parameter int FB_W        = 3,
    parameter int PF_MIN_FREE = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            enq_valid,
    input logic            enq_ready,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [31:0]     wr_addr,
    input logic [31:0]     wr_data,
    input logic            fence_valid,
    input logic [1:0]      fence_kind,
    input logic            disp_mem,
    input logic [FB_W-1:0] fill_free,
    input logic            pf_valid,
    input logic            stall_load,
    input logic            stall_store,
    input logic            stall_all,
    input logic            stall_dispatch
);

    p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        !enq_ready && !wr_ready |=> !enq_ready);

    p_load_from_fence_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_load) |-> $past(fence_valid && fence_kind != 2'd3));

    p_store_gate_r5: assert property (@(posedge clk) disable iff (rst)
        stall_store |-> !enq_valid);

    p_release_empty_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_store) |-> $past(!wr_valid));

    p_alloc_on_mem_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_dispatch) && !stall_all |-> disp_mem);

    p_throttle_r9: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> fill_free >= FB_W'(PF_MIN_FREE));

endmodule

bind store_drain_queue sdq_checker #(.FB_W(FB_W), .PF_MIN_FREE(PF_MIN_FREE)) u_sdq_chk (
    .clk            (clk),
    .rst            (rst),
    .enq_valid      (enq_valid),
    .enq_ready      (enq_ready),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .fence_valid    (fence_valid),
    .fence_kind     (fence_kind),
    .disp_mem       (disp_mem),
    .fill_free      (fill_free),
    .pf_valid       (pf_valid),
    .stall_load     (stall_load),
    .stall_store    (stall_store),
    .stall_all      (stall_all),
    .stall_dispatch (stall_dispatch)
);

// File: tb/test_store_drain_queue.sv
`timescale 1ns/1ps
module test_store_drain_queue;

    localparam int DEPTH = 8;
    localparam int LSB   = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        enq_valid, wr_ready, fence_valid, disp_mem;
    logic [31:0] enq_addr, enq_data;
    logic [1:0]  fence_kind;
    logic [2:0]  fill_free;
    logic        enq_ready, wr_valid, pf_valid;
    logic        stall_load, stall_store, stall_all, stall_dispatch;
    logic [31:0] wr_addr, wr_data, pf_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic [31:0] qa[$];
    logic [31:0] qd[$];
    bit          qs[$];
    bit          mp[3];
    int          mc[3];
    bit          mseen;

    always #2 clk = ~clk;

    store_drain_queue i_store_drain_queue (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_data(enq_data), .enq_ready(enq_ready),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .fence_valid(fence_valid), .fence_kind(fence_kind), .disp_mem(disp_mem),
        .fill_free(fill_free), .pf_valid(pf_valid), .pf_addr(pf_addr),
        .stall_load(stall_load), .stall_store(stall_store), .stall_all(stall_all),
        .stall_dispatch(stall_dispatch)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] line(input logic [31:0] a);
        return {a[31:LSB], {LSB{1'b0}}};
    endfunction

    task automatic quiet();
        enq_valid = 0; fence_valid = 0; fence_kind = 2'd3; disp_mem = 0;
    endtask

    // Check outputs against the model, then advance model at the edge.
    task automatic cycle();
        bit e_wv, e_rdy, e_pf, e_enq, e_drn, pfh, old_atom;
        int kk, ns;
        #0.5;
        e_wv  = qa.size() > 0;
        e_rdy = qa.size() < DEPTH;
        pfh = 0; kk = 0;
        for (int k = qa.size() - 1; k >= 1; k--) if (!qs[k]) begin pfh = 1; kk = k; end
        e_pf = pfh && (fill_free >= 3'd2);
        chk("R2", "wr_valid", wr_valid, e_wv);
        if (e_wv) begin
            chk("R2", "wr_addr", wr_addr, qa[0]);
            chk("R2", "wr_data", wr_data, qd[0]);
        end
        chk("R3", "enq_ready", enq_ready, e_rdy);
        chk("R9", "pf_valid", pf_valid, e_pf);
        if (e_pf) chk("R9", "pf_addr", pf_addr, line(qa[kk]));
        chk("R4", "stall_load", stall_load, mp[0] | mp[1] | mp[2]);
        chk("R5", "stall_store", stall_store, mp[1] | mp[2]);
        chk("R7", "stall_all", stall_all, mp[2]);
        chk("R6", "stall_dispatch", stall_dispatch, mp[2] | (mp[1] & (mseen | disp_mem)));
        e_enq = enq_valid && e_rdy;
        e_drn = e_wv && wr_ready;
        old_atom = mp[1];
        @(posedge clk);
        if (e_pf) qs[kk] = 1;
        if (e_drn) begin void'(qa.pop_front()); void'(qd.pop_front()); void'(qs.pop_front()); end
        if (e_enq) begin qa.push_back(enq_addr); qd.push_back(enq_data); qs.push_back(0); end
        ns = qa.size();
        for (int f = 0; f < 3; f++) begin
            if (fence_valid && fence_kind == 2'(f)) begin
                mp[f] = 1; mc[f] = ns;
            end else begin
                if (mp[f] && mc[f] == 0) mp[f] = 0;
                if (e_drn && mc[f] > 0) mc[f]--;
            end
        end
        if (!old_atom) mseen = 0;
        else if (disp_mem) mseen = 1;
        @(negedge clk);
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        quiet(); enq_valid = 1; enq_addr = a; enq_data = d; cycle(); enq_valid = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        for (int f = 0; f < 3; f++) begin mp[f] = 0; mc[f] = 0; end
        mseen = 0;
        rst = 1; quiet(); wr_ready = 0; fill_free = 3'd3; enq_addr = 0; enq_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #0.1;
        chk("R1", "enq_ready", enq_ready, 1);
        chk("R1", "wr_valid", wr_valid, 0);
        chk("R1", "pf_valid", pf_valid, 0);
        chk("R1", "stalls", {stall_load, stall_store, stall_all, stall_dispatch}, 0);

        // Fill to full with prefetch throttled (R3, R9)
        fill_free = 3'd1;
        for (int i = 0; i < DEPTH; i++) put(32'h1000_0000 + i * 32'h48, 32'hD000 + i);
        #0.1;
        chk("R3", "enq_ready when full", enq_ready, 0);
        chk("R9", "throttled pf_valid", pf_valid, 0);
        chk("R2", "head is oldest", wr_addr, 32'h1000_0000);
        enq_valid = 1; enq_addr = 32'hDEAD_0000; enq_data = 1; cycle(); quiet();
        fill_free = 3'd2;
        #0.1;
        chk("R9", "first pf line", pf_addr, line(32'h1000_0048));
        cycle();
        #0.1;
        chk("R9", "next pf line", pf_addr, line(32'h1000_0090));
        // Drain one, then enqueue and drain together (R3)
        wr_ready = 1; cycle();
        enq_valid = 1; enq_addr = 32'h2000_0000; enq_data = 32'h77; cycle(); quiet();
        #0.1;
        chk("R3", "simultaneous enq+drain count", enq_ready, 1);
        repeat (DEPTH + 2) cycle();
        #0.1;
        chk("R2", "drained empty", wr_valid, 0);

        // Store-load fence timing with two older stores (R4, R8)
        wr_ready = 0; fill_free = 3'd3;
        put(32'h3000_0000, 1); put(32'h3000_0100, 2);
        fence_valid = 1; fence_kind = 2'd0; cycle(); quiet();
        repeat (3) cycle();
        #0.1;
        chk("R4", "stall_load held", stall_load, 1);
        chk("R4", "stall_store untouched", stall_store, 0);
        wr_ready = 1; n = 0;
        for (int i = 0; i < 6; i++) begin #0.1; if (stall_load) n++; cycle(); end
        chk("R8", "stall cycles after drain", n, 3);

        // Fence with empty buffer lasts one cycle (R8)
        fence_valid = 1; fence_kind = 2'd0; cycle(); quiet(); n = 0;
        for (int i = 0; i < 4; i++) begin #0.1; if (stall_load) n++; cycle(); end
        chk("R8", "empty fence stall length", n, 1);

        // Atomic: dispatch stalls only after a younger memory op (R5, R6)
        wr_ready = 0;
        put(32'h4000_0000, 3);
        fence_valid = 1; fence_kind = 2'd1; cycle(); quiet();
        #0.1;
        chk("R5", "atomic stall_store", stall_store, 1);
        chk("R5", "atomic stall_all", stall_all, 0);
        chk("R6", "dispatch free before mem", stall_dispatch, 0);
        cycle();
        disp_mem = 1;
        #0.1;
        chk("R6", "dispatch stall on mem", stall_dispatch, 1);
        cycle();
        disp_mem = 0;
        #0.1;
        chk("R6", "dispatch stall sticky", stall_dispatch, 1);
        wr_ready = 1;
        repeat (4) cycle();
        #0.1;
        chk("R6", "dispatch released", stall_dispatch, 0);

        // Full fence (R7)
        wr_ready = 0;
        put(32'h5000_0000, 4); put(32'h5000_0040, 5);
        fence_valid = 1; fence_kind = 2'd2; cycle(); quiet();
        #0.1;
        chk("R7", "full stalls", {stall_load, stall_store, stall_all, stall_dispatch}, 4'hF);
        wr_ready = 1;
        repeat (5) cycle();
        #0.1;
        chk("R7", "full released", stall_all, 0);

        // Kind 3 ignored (R10)
        fence_valid = 1; fence_kind = 2'd3; cycle(); quiet();
        #0.1;
        chk("R10", "no stall on kind 3", {stall_load, stall_store, stall_all, stall_dispatch}, 0);

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            bit busy;
            busy = mp[0] | mp[1] | mp[2];
            enq_valid   = !(mp[1] | mp[2]) && ($urandom % 3 != 0);
            enq_addr    = $urandom;
            enq_data    = $urandom;
            wr_ready    = ($urandom % 2) == 1;
            fence_valid = !busy && ($urandom % 25 == 0);
            fence_kind  = 2'($urandom % 4);
            disp_mem    = ($urandom % 2) == 1;
            fill_free   = 3'($urandom % 5);
            cycle();
        end
        quiet();

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule